// File: doc/BRIEF.md
# Outbound Message Descriptor Ring Engine

This block walks a circular ring of 32-byte transmit descriptors kept in system memory, turning each one into a single message request for a downstream transmitter. Software fills descriptors, then tells the engine about each new one by writing a command bit in the mode register, which moves the hardware enqueue pointer forward by one slot. The engine reads each descriptor at the dequeue pointer through a word read port with a fixed one-cycle latency. It presents the request on a valid/ready channel, waits for a done or error pulse, and then moves on.

The back-pressure rules on the request channel are as follows. Once `msg_valid` rises, it stays high and every request field stays constant until a cycle in which `msg_ready` is also high. That cycle is the transfer. `msg_valid` drops in the following cycle. Only one request is ever outstanding. The engine ignores `rsp_done` and `rsp_err` except while it waits for the response to the request that was just accepted. The descriptor memory port has no stall: data for an address presented with `mem_rd_en` in one cycle must be on `mem_rd_data` in the next.

The register port is a single-cycle write with a combinational read. It uses a 3-bit word index: 0 mode, 1 status, 2 ring base, 3 dequeue pointer (read-only), 4 enqueue pointer (read-only). Mode bit 0 enables the engine. Mode bits 15:12 hold the ring size code c, which gives 2<<c entries (2 to 2048; codes above 10 behave as 10). Mode bit 1 is the enqueue command. Status bits are: 7 transmission error, 6 queue overflow, 4 queue full, 2 busy (live, read-only), 1 end of message, 0 queue empty.

Top module: `omsg_ring_engine`

## Requirements
- R1: After reset all five registers read 0, and `irq`, `msg_valid` and `mem_rd_en` are low.
- R2: A mode write with bit 1 set moves the enqueue pointer forward by 32 bytes, wrapping to the ring base after the last slot. The same write also updates bits 0 and 15:12. Bit 1 always reads back as 0.
- R3: An enqueue command that would make the enqueue pointer equal the dequeue pointer sets status bit 6 and leaves the enqueue pointer unchanged.
- R4: For the descriptor at address D, the request carries the following fields. `msg_src` is the word at D+4. `msg_dest` is bits 31:16 of the word at D+8, and `msg_mbox` is bits 1:0 of that word. `msg_prio` is bits 21:20 of the word at D+12. `msg_bytes` is the low bits of the word at D+24.
- R5: A request is raised only while the engine is enabled and the dequeue pointer differs from the enqueue pointer. It is held with stable fields until `msg_ready` is high.
- R6: A done response moves the dequeue pointer forward by 32 bytes. After slot (2<<c)-1 it wraps to the ring base.
- R7: A done response sets status bit 1 when bit 29 of the descriptor's attribute word (D+12) is set. It leaves bit 1 unchanged otherwise.
- R8: An error response sets status bit 7 and leaves the dequeue pointer on the failing descriptor. No further request is made until mode bit 0 is written 0 and then 1. After that, the same descriptor is fetched and sent again.
- R9: A transfer size that is not a power of two in 8..4096 sets status bit 7 without raising a request, with the same halt as R8.
- R10: Writing 1 to status bits 7, 6, 4, 1 or 0 clears them. Bit 0 sets when a done response makes the dequeue pointer equal the enqueue pointer. Bit 2 reads 1 while a descriptor is being fetched, offered or awaited.
- R11: Status bit 4 sets when an accepted enqueue leaves the ring full. `irq` is high whenever any of status bits 7, 6, 4 or 1 is set.
- R12: A write to the ring base register while the engine is disabled loads the base and both pointers with that value. The same write while the engine is enabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_rd_en | output | 1 | Descriptor word read request |
| mem_rd_addr | output | AW | Byte address of descriptor word |
| mem_rd_data | input | 32 | Read data, one cycle after request |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Transmitter accepts request |
| msg_dest | output | 16 | Destination identifier |
| msg_mbox | output | 2 | Mailbox number |
| msg_src | output | 32 | Payload source address |
| msg_bytes | output | SIZE_W | Transfer size in bytes |
| msg_prio | output | 2 | Request priority |
| rsp_done | input | 1 | Transmit completed pulse |
| rsp_err | input | 1 | Transmit failed pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs. The ring base is 32-byte aligned. The size code is changed only while both pointers sit at the base. Response pulses arrive only after a request has been accepted. Mode and base writes never occur in the same cycle. The bench programs one aligned base before enabling and writes the size code together with the enable, not with a pointer move. It raises `rsp_done` or `rsp_err` only in the cycle after a `msg_ready` handshake.

// File: rtl/omsg_pkg.sv
package omsg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LAST, ST_CHECK, ST_REQ, ST_WAIT, ST_HALT
  } eng_state_t;

  localparam logic [2:0] RA_MODE = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_BASE = 3'd2;
  localparam logic [2:0] RA_DEQ  = 3'd3;
  localparam logic [2:0] RA_ENQ  = 3'd4;

  localparam int DESC_BYTES = 32;
  localparam int SB_TE   = 7;
  localparam int SB_QO   = 6;
  localparam int SB_QF   = 4;
  localparam int SB_BUSY = 2;
  localparam int SB_EOM  = 1;
  localparam int SB_QE   = 0;
  localparam logic [7:0] W1C_MASK = 8'b1101_0011;
  localparam logic [7:0] IRQ_MASK = 8'b1101_0010;
  localparam int MODE_SIZE_LSB = 12;
endpackage

// File: rtl/omsg_ptr_step.sv
module omsg_ptr_step
  import omsg_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SZW      = 4,
  parameter int MAX_CODE = 10
) (
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  ptr_i,
  input  logic [SZW-1:0] code_i,
  output logic [AW-1:0]  next_o
);
  logic [SZW-1:0] code_eff;
  logic [AW-1:0]  span;
  logic [AW-1:0]  offs;

  always_comb begin
    code_eff = (code_i > SZW'(MAX_CODE)) ? SZW'(MAX_CODE) : code_i;
    span     = AW'(DESC_BYTES) << (code_eff + 1'b1);
    offs     = (ptr_i - base_i + AW'(DESC_BYTES)) & (span - 1'b1);
    next_o   = base_i + offs;
  end
endmodule

// File: rtl/omsg_ctrl_regs.sv
module omsg_ctrl_regs
  import omsg_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SZW      = 4,
  parameter int MAX_CODE = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  input  logic           adv_i,
  input  logic           te_i,
  input  logic           eom_i,
  input  logic           busy_i,
  output logic           unit_en_o,
  output logic [AW-1:0]  base_o,
  output logic [AW-1:0]  deq_o,
  output logic [AW-1:0]  enq_o,
  output logic [SZW-1:0] code_o,
  output logic [7:0]     stat_o,
  output logic           irq_o
);
  logic           en_q;
  logic [SZW-1:0] code_q;
  logic [AW-1:0]  base_q, deq_q, enq_q;
  logic [AW-1:0]  deq_nxt, enq_nxt, enq_nxt2;
  logic           mode_wr, stat_wr, base_wr, cmd, full_now, enq_take;
  logic [AW-1:0]  enq_after;
  logic [7:0]     set_vec, clr_vec, stat_q;

  omsg_ptr_step #(.AW(AW), .SZW(SZW), .MAX_CODE(MAX_CODE)) u_deq_step (
    .base_i(base_q), .ptr_i(deq_q), .code_i(code_q), .next_o(deq_nxt));
  omsg_ptr_step #(.AW(AW), .SZW(SZW), .MAX_CODE(MAX_CODE)) u_enq_step (
    .base_i(base_q), .ptr_i(enq_q), .code_i(code_q), .next_o(enq_nxt));
  omsg_ptr_step #(.AW(AW), .SZW(SZW), .MAX_CODE(MAX_CODE)) u_enq_step2 (
    .base_i(base_q), .ptr_i(enq_nxt), .code_i(code_q), .next_o(enq_nxt2));

  always_comb begin
    mode_wr   = wr_en && (addr == RA_MODE);
    stat_wr   = wr_en && (addr == RA_STAT);
    base_wr   = wr_en && (addr == RA_BASE) && !en_q;
    cmd       = mode_wr && wdata[1];
    full_now  = (enq_nxt == deq_q);
    enq_take  = cmd && !full_now;
    enq_after = enq_take ? enq_nxt : enq_q;
    set_vec          = '0;
    set_vec[SB_TE]   = te_i;
    set_vec[SB_QO]   = cmd && full_now;
    set_vec[SB_QF]   = enq_take && (enq_nxt2 == deq_q);
    set_vec[SB_EOM]  = eom_i;
    set_vec[SB_QE]   = adv_i && (deq_nxt == enq_after);
    clr_vec          = stat_wr ? wdata[7:0] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
      base_q <= '0;
      deq_q  <= '0;
      enq_q  <= '0;
    end else begin
      if (mode_wr) begin
        en_q   <= wdata[0];
        code_q <= wdata[MODE_SIZE_LSB +: SZW];
      end
      if (base_wr) begin
        base_q <= AW'(wdata);
        deq_q  <= AW'(wdata);
        enq_q  <= AW'(wdata);
      end else begin
        if (enq_take) enq_q <= enq_nxt;
        if (adv_i)    deq_q <= deq_nxt;
      end
    end
  end

  for (genvar g = 0; g < 8; g++) begin : g_stat
    if (W1C_MASK[g]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n)          stat_q[g] <= 1'b0;
        else if (set_vec[g]) stat_q[g] <= 1'b1;
        else if (clr_vec[g]) stat_q[g] <= 1'b0;
      end
    end else begin : g_tie
      assign stat_q[g] = 1'b0;
    end
  end

  always_comb begin
    stat_o          = stat_q;
    stat_o[SB_BUSY] = busy_i;
    unique case (addr)
      RA_MODE: rdata = (32'(code_q) << MODE_SIZE_LSB) | 32'(en_q);
      RA_STAT: rdata = 32'(stat_o);
      RA_BASE: rdata = 32'(base_q);
      RA_DEQ:  rdata = 32'(deq_q);
      RA_ENQ:  rdata = 32'(enq_q);
      default: rdata = 32'h0;
    endcase
  end

  assign unit_en_o = en_q;
  assign base_o    = base_q;
  assign deq_o     = deq_q;
  assign enq_o     = enq_q;
  assign code_o    = code_q;
  assign irq_o     = |(stat_q & IRQ_MASK);
endmodule

// File: rtl/omsg_desc_engine.sv
module omsg_desc_engine
  import omsg_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic [AW-1:0]     deq_ptr,
  input  logic [AW-1:0]     enq_ptr,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [15:0]       msg_dest,
  output logic [1:0]        msg_mbox,
  output logic [31:0]       msg_src,
  output logic [SIZE_W-1:0] msg_bytes,
  output logic [1:0]        msg_prio,
  input  logic              rsp_done,
  input  logic              rsp_err,
  output logic              adv_o,
  output logic              te_o,
  output logic              eom_o,
  output logic              busy_o,
  output logic              halted_o
);
  localparam int NWORDS = 4;
  localparam logic [31:0] MAX_BYTES = 32'(1) << (SIZE_W - 1);

  eng_state_t  state_q, state_d;
  logic [1:0]  widx_q;
  logic        rd_vld_q;
  logic [1:0]  rd_tag_q;
  logic [31:0] src_q, size_q;
  logic [15:0] dest_q;
  logic [1:0]  mbox_q, prio_q;
  logic        eom_req_q;
  logic        size_ok;

  function automatic logic [AW-1:0] word_off(input logic [1:0] idx);
    unique case (idx)
      2'd0: word_off = AW'(4);
      2'd1: word_off = AW'(8);
      2'd2: word_off = AW'(12);
      default: word_off = AW'(24);
    endcase
  endfunction

  assign mem_rd_en   = (state_q == ST_FETCH);
  assign mem_rd_addr = deq_ptr + word_off(widx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      rd_tag_q <= '0;
    end else begin
      rd_vld_q <= mem_rd_en;
      rd_tag_q <= widx_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0; dest_q <= '0; mbox_q <= '0;
      prio_q <= '0; eom_req_q <= 1'b0; size_q <= '0;
    end else if (rd_vld_q) begin
      unique case (rd_tag_q)
        2'd0: src_q <= mem_rd_data;
        2'd1: begin
          dest_q <= mem_rd_data[31:16];
          mbox_q <= mem_rd_data[1:0];
        end
        2'd2: begin
          eom_req_q <= mem_rd_data[29];
          prio_q    <= mem_rd_data[21:20];
        end
        default: size_q <= mem_rd_data;
      endcase
    end
  end

  assign size_ok = (size_q >= 32'd8) && (size_q <= MAX_BYTES) &&
                   ((size_q & (size_q - 32'd1)) == 32'd0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (unit_en && (deq_ptr != enq_ptr)) state_d = ST_FETCH;
      ST_FETCH: if (widx_q == 2'(NWORDS - 1)) state_d = ST_LAST;
      ST_LAST:  state_d = ST_CHECK;
      ST_CHECK: state_d = size_ok ? ST_REQ : ST_HALT;
      ST_REQ:   if (msg_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_err)       state_d = ST_HALT;
        else if (rsp_done) state_d = ST_IDLE;
      end
      ST_HALT:  if (!unit_en) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FETCH) widx_q <= widx_q + 2'd1;
      else                     widx_q <= '0;
    end
  end

  assign msg_valid = (state_q == ST_REQ);
  assign msg_dest  = dest_q;
  assign msg_mbox  = mbox_q;
  assign msg_src   = src_q;
  assign msg_bytes = size_q[SIZE_W-1:0];
  assign msg_prio  = prio_q;

  assign adv_o    = (state_q == ST_WAIT) && rsp_done && !rsp_err;
  assign eom_o    = adv_o && eom_req_q;
  assign te_o     = ((state_q == ST_CHECK) && !size_ok) ||
                    ((state_q == ST_WAIT) && rsp_err);
  assign busy_o   = (state_q != ST_IDLE) && (state_q != ST_HALT);
  assign halted_o = (state_q == ST_HALT);
endmodule

// File: rtl/omsg_ring_engine.sv
module omsg_ring_engine
  import omsg_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SZW      = 4,
  parameter int MAX_CODE = 10,
  parameter int SIZE_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [15:0]       msg_dest,
  output logic [1:0]        msg_mbox,
  output logic [31:0]       msg_src,
  output logic [SIZE_W-1:0] msg_bytes,
  output logic [1:0]        msg_prio,
  input  logic              rsp_done,
  input  logic              rsp_err,
  output logic              irq
);
  logic           unit_en, eng_adv, eng_te, eng_eom, eng_busy, eng_halted;
  logic [AW-1:0]  ring_base, deq_ptr, enq_ptr;
  logic [SZW-1:0] size_code;
  logic [7:0]     stat_bits;

  omsg_ctrl_regs #(.AW(AW), .SZW(SZW), .MAX_CODE(MAX_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .adv_i(eng_adv), .te_i(eng_te), .eom_i(eng_eom), .busy_i(eng_busy),
    .unit_en_o(unit_en), .base_o(ring_base), .deq_o(deq_ptr), .enq_o(enq_ptr),
    .code_o(size_code), .stat_o(stat_bits), .irq_o(irq));

  omsg_desc_engine #(.AW(AW), .SIZE_W(SIZE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
    .deq_ptr(deq_ptr), .enq_ptr(enq_ptr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_mbox(msg_mbox), .msg_src(msg_src), .msg_bytes(msg_bytes),
    .msg_prio(msg_prio), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .adv_o(eng_adv), .te_o(eng_te), .eom_o(eng_eom), .busy_o(eng_busy),
    .halted_o(eng_halted));
endmodule

// File: rtl/omsg_ring_engine_sva.sv
module omsg_ring_engine_sva #(
  parameter int AW       = 32,
  parameter int SZW      = 4,
  parameter int MAX_CODE = 10,
  parameter int SIZE_W   = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [15:0]       msg_dest,
  input logic [1:0]        msg_mbox,
  input logic [31:0]       msg_src,
  input logic [SIZE_W-1:0] msg_bytes,
  input logic [1:0]        msg_prio,
  input logic              rsp_done,
  input logic              unit_en,
  input logic              eng_halted,
  input logic [AW-1:0]     ring_base,
  input logic [AW-1:0]     deq_ptr,
  input logic [AW-1:0]     enq_ptr,
  input logic [SZW-1:0]    size_code,
  input logic [7:0]        stat_bits
);
  logic [SZW-1:0] code_c;
  logic [AW-1:0]  span_c, enq_step_c;
  logic           cmd_when_full;

  always_comb begin
    code_c        = (size_code > SZW'(MAX_CODE)) ? SZW'(MAX_CODE) : size_code;
    span_c        = AW'(32) << (code_c + 1'b1);
    enq_step_c    = ring_base + ((enq_ptr - ring_base + AW'(32)) & (span_c - 1'b1));
    cmd_when_full = reg_wr_en && (reg_addr == 3'd0) && reg_wdata[1] &&
                    (enq_step_c == deq_ptr);
  end

  p_cmd_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> !reg_rdata[1]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_when_full |=> (stat_bits[6] && $stable(enq_ptr)));

  p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable({msg_dest, msg_mbox, msg_src, msg_bytes, msg_prio})));

  p_req_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (unit_en && (deq_ptr != enq_ptr)));

  p_ptr_in_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((deq_ptr - ring_base) < span_c) && ((enq_ptr - ring_base) < span_c));

  p_eom_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_bits[1]) |-> $past(rsp_done));

  p_halt_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_halted && unit_en) |=> ($stable(deq_ptr) && !msg_valid));
endmodule

bind omsg_ring_engine omsg_ring_engine_sva #(
  .AW(AW), .SZW(SZW), .MAX_CODE(MAX_CODE), .SIZE_W(SIZE_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_mbox(msg_mbox),
  .msg_src(msg_src), .msg_bytes(msg_bytes), .msg_prio(msg_prio),
  .rsp_done(rsp_done), .unit_en(unit_en), .eng_halted(eng_halted),
  .ring_base(ring_base), .deq_ptr(deq_ptr), .enq_ptr(enq_ptr),
  .size_code(size_code), .stat_bits(stat_bits));

// File: tb/omsg_ring_engine_test.sv
`timescale 1ns/1ps
module omsg_ring_engine_test;
  localparam int AW = 32;
  localparam int SIZE_W = 13;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic msg_valid;
  logic msg_ready = 1'b0;
  logic [15:0] msg_dest;
  logic [1:0] msg_mbox;
  logic [31:0] msg_src;
  logic [SIZE_W-1:0] msg_bytes;
  logic [1:0] msg_prio;
  logic rsp_done = 1'b0;
  logic rsp_err = 1'b0;
  logic irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] mem [128];

  always #4 clk = ~clk;

  omsg_ring_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_mbox(msg_mbox),
    .msg_src(msg_src), .msg_bytes(msg_bytes), .msg_prio(msg_prio),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .irq(irq));

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[8:2]];

  // {dest[16], mbox[2], src[32], size[16], attr[32]}
  localparam logic [97:0] VEC [5] = '{
    {16'h1234, 2'd1, 32'hA000_0000, 16'd8,    32'h2000_0000},
    {16'hBEEF, 2'd3, 32'h0000_4400, 16'd4096, 32'h0010_0000},
    {16'h0001, 2'd0, 32'h1234_5600, 16'd256,  32'h2020_0000},
    {16'hFFFF, 2'd2, 32'hFFFF_FF00, 16'd64,   32'h0030_0000},
    {16'h5A5A, 2'd1, 32'h0BAD_0000, 16'd16,   32'h2030_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] slot, input logic [97:0] v);
    int w;
    w = int'(slot[8:2]);
    mem[w+0] = 32'hDEAD_0000;
    mem[w+1] = v[79:48];
    mem[w+2] = {v[97:82], 14'h0, v[81:80]};
    mem[w+3] = v[31:0];
    mem[w+4] = 32'hDEAD_0004;
    mem[w+5] = 32'hDEAD_0005;
    mem[w+6] = {16'h0, v[47:32]};
    mem[w+7] = 32'hDEAD_0007;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (msg_valid) begin seen = 1'b1; break; end
    end
  endtask

  task automatic xfer(input bit err);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk("R5 valid drops after handshake", 32'(msg_valid), 32'd0);
    if (err) rsp_err = 1'b1; else rsp_done = 1'b1;
    @(negedge clk);
    rsp_err = 1'b0; rsp_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic no_request(input string req);
    bit any;
    any = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (msg_valid) any = 1'b1;
    end
    chk(req, 32'(any), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    bit seen;
    for (int k = 0; k < 128; k++) mem[k] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), d);
      chk("R1 register reset", d, 32'h0);
    end
    chk("R1 irq low", 32'(irq), 32'd0);
    chk("R1 request and read idle", 32'({msg_valid, mem_rd_en}), 32'd0);

    // R12: base load while disabled
    reg_write(3'd2, BASE);
    reg_read(3'd3, d); chk("R12 deq loaded", d, BASE);
    reg_read(3'd4, d); chk("R12 enq loaded", d, BASE);
    reg_write(3'd0, 32'h0000_1001);
    reg_read(3'd0, d); chk("R2 mode readback", d, 32'h0000_1001);

    // vector walk
    for (int i = 0; i < 5; i++) begin
      logic [97:0] v;
      logic [31:0] src0;
      bit held;
      v = VEC[i];
      put_desc(BASE + 32'((i % 4) * 32), v);
      reg_write(3'd0, 32'h0000_1003);
      reg_read(3'd0, d); chk("R2 command bit reads 0", d, 32'h0000_1001);
      reg_read(3'd4, d); chk("R2 enq advance/wrap", d, BASE + 32'(((i + 1) % 4) * 32));
      wait_valid(seen);
      chk("R5 request raised", 32'(seen), 32'd1);
      chk("R4 source address", msg_src, v[79:48]);
      chk("R4 dest/mbox/prio", {12'h0, msg_dest, msg_mbox, msg_prio},
          {12'h0, v[97:82], v[81:80], v[21:20]});
      chk("R4 byte count", 32'(msg_bytes), 32'(v[47:32]));
      src0 = msg_src;
      held = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (!msg_valid || msg_src !== src0) held = 1'b0;
      end
      chk("R5 held under back-pressure", 32'(held), 32'd1);
      xfer(1'b0);
      reg_read(3'd3, d); chk("R6 deq advance/wrap", d, BASE + 32'(((i + 1) % 4) * 32));
      reg_read(3'd1, d); chk("R7 R10 status eom/empty", d, v[29] ? 32'h3 : 32'h1);
      chk("R11 irq follows eom", 32'(irq), 32'(v[29]));
      reg_write(3'd1, 32'hFF);
      reg_read(3'd1, d); chk("R10 write-1-clear", d, 32'h0);
    end

    // R3/R11: fill ring while disabled, then overflow
    reg_write(3'd0, 32'h0000_1000);
    put_desc(BASE + 32'h20, VEC[0]);
    put_desc(BASE + 32'h40, VEC[1]);
    put_desc(BASE + 32'h60, VEC[2]);
    for (int k = 0; k < 3; k++) reg_write(3'd0, 32'h0000_1002);
    reg_read(3'd1, d); chk("R11 queue full flag", d, 32'h10);
    chk("R11 irq on full", 32'(irq), 32'd1);
    reg_write(3'd0, 32'h0000_1002);
    reg_read(3'd4, d); chk("R3 enq unchanged on overflow", d, BASE);
    reg_read(3'd1, d); chk("R3 overflow flag", d, 32'h50);
    reg_write(3'd1, 32'hFF);

    // R8: error halts
    reg_write(3'd0, 32'h0000_1001);
    wait_valid(seen);
    reg_read(3'd1, d); chk("R10 busy while offering", d, 32'h4);
    chk("R8 first request source", msg_src, VEC[0][79:48]);
    xfer(1'b1);
    reg_read(3'd1, d); chk("R8 error flag", d, 32'h80);
    reg_read(3'd3, d); chk("R8 deq held", d, BASE + 32'h20);
    no_request("R8 no request while halted");
    reg_write(3'd2, 32'h200);
    reg_read(3'd2, d); chk("R12 base write ignored when enabled", d, BASE);
    reg_write(3'd1, 32'hFF);
    reg_write(3'd0, 32'h0000_1000);
    reg_write(3'd0, 32'h0000_1001);
    wait_valid(seen);
    chk("R8 retry after re-enable", msg_src, VEC[0][79:48]);
    xfer(1'b0);
    wait_valid(seen);
    chk("R6 next slot source", msg_src, VEC[1][79:48]);
    xfer(1'b0);
    wait_valid(seen);
    chk("R6 last slot source", msg_src, VEC[2][79:48]);
    xfer(1'b0);
    reg_read(3'd3, d); chk("R6 deq wrapped to base", d, BASE);
    reg_read(3'd1, d); chk("R7 R10 drain status", d, 32'h3);
    reg_write(3'd1, 32'hFF);

    // R9: bad size
    put_desc(BASE, {16'h7777, 2'd0, 32'h0000_8000, 16'd12, 32'h2000_0000});
    reg_write(3'd0, 32'h0000_1003);
    no_request("R9 no request for bad size");
    reg_read(3'd1, d); chk("R9 error flag for bad size", d, 32'h80);
    reg_read(3'd3, d); chk("R9 deq held", d, BASE);

    finish_run();
  end
endmodule